// File: doc/BRIEF.md
# Board Data Sequence Checker

This block watches one input channel's stream of already-classified control tokens. Each token marks a structural point in one board's data: the opening word, the second header, a standalone "no data" marker, a sub-board trailer, the first trailer, and the second trailer, which closes the board's data. The block follows the expected order with a small state machine. It raises two flags. The fatal flag means the checker can no longer trust its position in the stream. The recoverable flag means an expected control token was skipped but the closing word still arrived.

The upstream decoder presents one token per clock with a valid strobe. The fatal flag stays set until reset, so it can drive a reset request. The recoverable flag describes only the current board and clears when the next opening word arrives. The number of sub-board trailers allowed inside one board is a parameter.

Top module: `evt_seq_checker`

## Requirements
- R1: Token codes on `tokCode` are 1 opening word, 2 second header, 3 standalone marker, 4 sub-board trailer, 5 first trailer and 6 closing word. Codes 0 and 7 are ignored, and so is any cycle with `tokValid` low. Both flags are low after reset.
- R2: The ordered sequence opening, second header, 0 to MAX_SUB sub-board trailers, first trailer, closing word sets neither flag. A standalone marker between boards (after reset or after a closing word) also sets neither flag.
- R3: An opening word or a standalone marker that arrives after an opening word and before the closing word sets the fatal flag.
- R4: A second header that arrives after a second header or after a first trailer, and before the closing word, sets the fatal flag.
- R5: A sub-board trailer beyond MAX_SUB in one board, or any sub-board trailer after the first trailer, sets the fatal flag.
- R6: A second first trailer before the closing word sets the fatal flag.
- R7: A closing word that arrives after the opening word but before any first trailer sets the fatal flag.
- R8: Between boards, a second header, sub-board trailer, first trailer or closing word sets the recoverable flag. Right after an opening word, a sub-board trailer or first trailer (so the second header is missing) also sets it. None of these sets the fatal flag.
- R9: Once set, the fatal flag stays high until reset, whatever tokens follow.
- R10: Any opening word clears the recoverable flag.
- R11: Resynchronisation works as follows. After a fatal token the checker is between boards, except that a fatal opening word starts a new board. After a recoverable token the checker continues as if the missing tokens had arrived.
- R12: Each flag changes one clock after the valid token that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tokValid | input | 1 | A token is present this cycle |
| tokCode | input | 3 | Token type code (see R1) |
| lostInDataErr | output | 1 | Fatal sequence error, held until reset |
| lostInEventErr | output | 1 | Recoverable missing-token error |

## Verification
The assertions take for granted that `tokCode` is meaningful only when `tokValid` is high. They also assume that a new token may arrive on every clock with no gap. The stimulus drives every code in each cycle, including the reserved codes and cycles with the strobe low, so the assertions about ignored input are also exercised. Every four-token sequence from reset is applied, and directed sequences reach the sub-board trailer limit and the flag-clearing cases.

// File: rtl/evtseq_pkg.sv
package evtseq_pkg;
  typedef enum logic [2:0] {
    TOK_RSVD0  = 3'd0,
    TOK_FIRST  = 3'd1,
    TOK_HDR2   = 3'd2,
    TOK_LONE   = 3'd3,
    TOK_SUBTRL = 3'd4,
    TOK_TRL1   = 3'd5,
    TOK_TRL2   = 3'd6,
    TOK_RSVD7  = 3'd7
  } tok_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_DATA = 3'd2,
    ST_TRL1 = 3'd3,
    ST_DONE = 3'd4
  } st_e;

  typedef struct packed {
    logic setFatal;
    logic setLost;
    logic clrLost;
    logic subInc;
    logic subClr;
  } strobe_t;
endpackage

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evtseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tokValid,
  input  logic [2:0] tokCode,
  input  logic    subFull,
  output strobe_t ctlStrobe,
  output st_e     curState
);
  st_e  nxtState;
  tok_e tok;
  logic between;

  assign tok     = tok_e'(tokCode);
  assign between = (curState == ST_IDLE) || (curState == ST_DONE);

  always_comb begin
    nxtState  = curState;
    ctlStrobe = '0;
    if (tokValid) begin
      case (tok)
        TOK_FIRST: begin
          ctlStrobe.clrLost = 1'b1;
          ctlStrobe.subClr  = 1'b1;
          nxtState          = ST_HDR;
          if (!between) ctlStrobe.setFatal = 1'b1;
        end
        TOK_LONE: begin
          if (!between) begin
            ctlStrobe.setFatal = 1'b1;
            nxtState           = ST_IDLE;
          end
        end
        TOK_HDR2: begin
          if (between) begin
            ctlStrobe.setLost = 1'b1;
            ctlStrobe.subClr  = 1'b1;
            nxtState          = ST_DATA;
          end else if (curState == ST_HDR) begin
            nxtState = ST_DATA;
          end else begin
            ctlStrobe.setFatal = 1'b1;
            nxtState           = ST_IDLE;
          end
        end
        TOK_SUBTRL: begin
          if (between) begin
            ctlStrobe.setLost = 1'b1;
            ctlStrobe.subClr  = 1'b1;
            ctlStrobe.subInc  = 1'b1;
            nxtState          = ST_DATA;
          end else if (curState == ST_HDR) begin
            ctlStrobe.setLost = 1'b1;
            ctlStrobe.subInc  = 1'b1;
            nxtState          = ST_DATA;
          end else if (curState == ST_DATA && !subFull) begin
            ctlStrobe.subInc = 1'b1;
          end else begin
            ctlStrobe.setFatal = 1'b1;
            nxtState           = ST_IDLE;
          end
        end
        TOK_TRL1: begin
          if (between || curState == ST_HDR) begin
            ctlStrobe.setLost = 1'b1;
            nxtState          = ST_TRL1;
          end else if (curState == ST_DATA) begin
            nxtState = ST_TRL1;
          end else begin
            ctlStrobe.setFatal = 1'b1;
            nxtState           = ST_IDLE;
          end
        end
        TOK_TRL2: begin
          if (between) begin
            ctlStrobe.setLost = 1'b1;
            nxtState          = ST_DONE;
          end else if (curState == ST_TRL1) begin
            nxtState = ST_DONE;
          end else begin
            ctlStrobe.setFatal = 1'b1;
            nxtState           = ST_IDLE;
          end
        end
        default: nxtState = curState;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end
endmodule

// File: rtl/evt_seq_datapath.sv
module evt_seq_datapath
  import evtseq_pkg::*;
#(
  parameter int MAX_SUB = 2
)(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t ctlStrobe,
  output logic    subFull,
  output logic    fatalFlag,
  output logic    lostFlag
);
  localparam int CNT_W = (MAX_SUB < 1) ? 1 : $clog2(MAX_SUB + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SUB);

  logic [CNT_W-1:0] subCnt;

  assign subFull = (subCnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
    end else if (ctlStrobe.subClr) begin
      subCnt <= ctlStrobe.subInc ? CNT_W'(1) : '0;
    end else if (ctlStrobe.subInc) begin
      subCnt <= subCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   fatalFlag <= 1'b0;
    else if (ctlStrobe.setFatal) fatalFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lostFlag <= 1'b0;
    else if (ctlStrobe.setLost) lostFlag <= 1'b1;
    else if (ctlStrobe.clrLost) lostFlag <= 1'b0;
  end
endmodule

// File: rtl/evt_seq_checker.sv
module evt_seq_checker
  import evtseq_pkg::*;
#(
  parameter int MAX_SUB = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tokValid,
  input  logic [2:0] tokCode,
  output logic       lostInDataErr,
  output logic       lostInEventErr
);
  strobe_t ctlStrobe;
  st_e     fsmState;
  logic    subFull;

  evt_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokCode(tokCode),
    .subFull(subFull), .ctlStrobe(ctlStrobe), .curState(fsmState)
  );

  evt_seq_datapath #(.MAX_SUB(MAX_SUB)) u_dp (
    .clk(clk), .rstN(rstN), .ctlStrobe(ctlStrobe), .subFull(subFull),
    .fatalFlag(lostInDataErr), .lostFlag(lostInEventErr)
  );
endmodule

// File: rtl/evt_seq_checker_sva.sv
module evt_seq_checker_sva (
  input logic       clk,
  input logic       rstN,
  input logic       tokValid,
  input logic [2:0] tokCode,
  input logic [2:0] fsmState,
  input logic       lostInDataErr,
  input logic       lostInEventErr
);
  logic tokLive, inBoard;
  assign tokLive = tokValid && (tokCode != 3'd0) && (tokCode != 3'd7);
  assign inBoard = (fsmState == 3'd1) || (fsmState == 3'd2) || (fsmState == 3'd3);

  assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    lostInDataErr |=> lostInDataErr);

  assert_ignored_token_R1: assert property (@(posedge clk) disable iff (!rstN)
    !tokLive |=> $stable(lostInDataErr) && $stable(lostInEventErr) && $stable(fsmState));

  assert_first_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokCode == 3'd1) |=> !lostInEventErr);

  assert_nested_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && inBoard && (tokCode == 3'd1 || tokCode == 3'd3)) |=> lostInDataErr);

  assert_early_close_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokCode == 3'd6 && (fsmState == 3'd1 || fsmState == 3'd2)) |=> lostInDataErr);

  assert_dup_trl1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokCode == 3'd5 && fsmState == 3'd3) |=> lostInDataErr);

  assert_stray_between_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && !inBoard && tokCode >= 3'd4 && tokCode <= 3'd6) |=> lostInEventErr);
endmodule

bind evt_seq_checker evt_seq_checker_sva u_sva (
  .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokCode(tokCode),
  .fsmState(fsmState), .lostInDataErr(lostInDataErr), .lostInEventErr(lostInEventErr)
);

// File: tb/test_evt_seq_checker.sv
module test_evt_seq_checker;
  localparam int MAX_SUB = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokValid = 1'b0;
  logic [2:0] tokCode = 3'd0;
  logic lostInDataErr, lostInEventErr;

  int nChk = 0, nBad = 0, cyc = 0;
  bit done = 1'b0;

  // bench-side expectation (from R1..R11)
  int  mPos;   // 0 between, 1 opened, 2 second header seen, 3 first trailer seen
  int  mSub;
  bit  mFatal, mLost;

  always #2 clk = ~clk;  // 250 MHz

  evt_seq_checker #(.MAX_SUB(MAX_SUB)) i_evt_seq_checker (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokCode(tokCode),
    .lostInDataErr(lostInDataErr), .lostInEventErr(lostInEventErr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      nBad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic check(input string req);
    nChk++;
    if (lostInDataErr !== mFatal || lostInEventErr !== mLost) begin
      nBad++;
      $display("FAIL %s: actual fatal=%b lost=%b expected fatal=%b lost=%b",
               req, lostInDataErr, lostInEventErr, mFatal, mLost);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tokValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mPos = 0; mSub = 0; mFatal = 0; mLost = 0;
    check("R1 reset");
  endtask

  function automatic string expStep(input bit v, input logic [2:0] c);
    string r = "R1 ignored";
    if (!v || c == 3'd0 || c == 3'd7) return r;
    case (c)
      3'd1: begin
        mLost = 0; mSub = 0;
        if (mPos != 0) begin mFatal = 1; r = "R3 nested opening"; end
        else r = "R10 opening";
        mPos = 1;
      end
      3'd3: begin
        if (mPos != 0) begin mFatal = 1; mPos = 0; r = "R3 marker inside board"; end
        else r = "R2 marker between boards";
      end
      3'd2: begin
        if (mPos == 0) begin mLost = 1; mSub = 0; mPos = 2; r = "R8 stray header"; end
        else if (mPos == 1) begin mPos = 2; r = "R2 header"; end
        else begin mFatal = 1; mPos = 0; r = "R4 extra header"; end
      end
      3'd4: begin
        if (mPos == 0) begin mLost = 1; mSub = 1; mPos = 2; r = "R8 stray subtrailer"; end
        else if (mPos == 1) begin mLost = 1; mSub++; mPos = 2; r = "R8 missing header"; end
        else if (mPos == 2 && mSub < MAX_SUB) begin mSub++; r = "R2 subtrailer"; end
        else begin mFatal = 1; mPos = 0; r = "R5 extra subtrailer"; end
      end
      3'd5: begin
        if (mPos <= 1) begin mLost = 1; mPos = 3; r = "R8 missing before trailer"; end
        else if (mPos == 2) begin mPos = 3; r = "R2 trailer"; end
        else begin mFatal = 1; mPos = 0; r = "R6 extra trailer"; end
      end
      default: begin
        if (mPos == 0) begin mLost = 1; r = "R8 stray close"; end
        else if (mPos == 3) r = "R2 close";
        else begin mFatal = 1; r = "R7 early close"; end
        mPos = 0;
      end
    endcase
    return r;
  endfunction

  task automatic send(input bit v, input logic [2:0] c);
    string r;
    tokValid = v; tokCode = c;
    r = expStep(v, c);
    @(negedge clk);
    tokValid = 1'b0; tokCode = 3'd0;
    check({r, " R12 timing R11 resync R9 sticky"});
  endtask

  initial begin
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    doReset();

    // exhaustive four-token sweep from reset
    for (int s = 0; s < 4096; s++) begin
      doReset();
      for (int k = 0; k < 4; k++) send(1'b1, 3'((s >> (3 * k)) & 7));
    end

    // R2: legal boards with 0..MAX_SUB subtrailers, markers in between
    doReset();
    for (int n = 0; n <= MAX_SUB; n++) begin
      send(1, 3'd1); send(1, 3'd2);
      for (int j = 0; j < n; j++) send(1, 3'd4);
      send(1, 3'd5); send(1, 3'd6); send(1, 3'd3);
    end

    // R5: one subtrailer beyond the limit
    doReset();
    send(1, 3'd1); send(1, 3'd2);
    for (int j = 0; j <= MAX_SUB; j++) send(1, 3'd4);

    // R9: fatal stays through many legal boards
    for (int n = 0; n < 5; n++) begin
      send(1, 3'd1); send(1, 3'd2); send(1, 3'd5); send(1, 3'd6);
    end

    // R1/R10: invalid strobe with opening code leaves recoverable flag set
    doReset();
    send(1, 3'd6);
    send(0, 3'd1); send(0, 3'd1); send(1, 3'd7); send(1, 3'd0);
    send(1, 3'd1);
    send(1, 3'd4); send(1, 3'd4); send(1, 3'd4); send(1, 3'd5); send(1, 3'd6);

    // random walk with valid gaps
    doReset();
    for (int n = 0; n < 3000; n++) send(1'($urandom_range(0, 5) != 0), 3'($urandom_range(0, 7)));

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule